// File: doc/BRIEF.md
# Recursive Vertical-Crosswise 32x32 Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns the exact 64-bit product. The product is built up level by level. The leaf is an 8x8 core. It sums every crosswise bit-pair product that lands in one output column in a single combinational step, with no shift-and-add sequence. An NxN core forms 2N-1 such column sums.

Four 8x8 cores make up a 16x16 stage, and four 16x16 stages make up the 32x32 level. At each level the four quarter products are aligned and added. For an operand width n, with each operand split into high (H) and low (L) halves, the product is LL + ((LH + HL) << n/2) + (HH << n).

At the top level the four aligned quarter products pass through two rows of 3:2 carry-save compressors. The resulting sum and carry words are then resolved by a Kogge-Stone parallel-prefix adder with log2 prefix stages.

The datapath is combinational. A single output register, present by default, captures the product on each cycle where the input strobe is high. The strobe is delayed by one cycle to form the output valid flag.

Top module: `vx_mul32`

## Requirements
- R1: With `in_valid` high, `prod` on the following cycle equals the exact unsigned integer product of `op_a` and `op_b`. This holds for corner operands such as alternating bit patterns, and for arbitrary operands. For example, 0xFFFFFFFF x 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R2: `out_valid` is `in_valid` delayed by exactly one clock cycle, including when `in_valid` is high on consecutive cycles.
- R3: On a cycle where `in_valid` is low, `prod` keeps its previous value on the next cycle, whatever `op_a` and `op_b` carry.
- R4: While `rst_n` is low at a rising clock edge, `out_valid` becomes 0 and `prod` becomes 0, regardless of `in_valid`.
- R5: If either operand is zero while `in_valid` is high, `prod` is zero on the next cycle.
- R6: If one operand is 1 while `in_valid` is high, `prod` on the next cycle equals the other operand zero-extended to 64 bits.
- R7: Carries that ripple across quarter-product boundaries and through the upper half of the result are resolved exactly, and the prefix adder's result equals the sum of its two carry-save inputs modulo 2^64. Examples:
  - 0xFFFFFFFF x 2 gives 0x1FFFFFFFE.
  - 0x0001FFFF x 0x0001FFFF gives 0x3FFFC0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High when the operands are to be multiplied |
| op_a | input | 32 | Unsigned multiplicand |
| op_b | input | 32 | Unsigned multiplier |
| prod | output | 64 | Registered 64-bit product |
| out_valid | output | 1 | High one cycle after an accepted operand pair |

## Verification
The assertions check five behaviours on every cycle:
- the one-cycle valid delay;
- the exact product against a behavioural multiply;
- the hold of `prod` on idle cycles;
- the zero-operand result;
- that the Kogge-Stone sum always equals the plain sum of the carry-save words.

Only the bench scenarios show two further behaviours. One is the reset value of the product while the strobe is held high during reset. The other is that particular carry patterns (all-ones operands, ripples across the 16-bit seams, identity operands) come out right. These need chosen operand values, and a random stream rarely reaches them.

// File: rtl/vx_pkg.sv
// Package: vx_pkg
// Shared sizing constants for the vertical-crosswise multiplier tree.
// Assumes the top operand width is four times the leaf core width.
package vx_pkg;
    localparam int unsigned VX_OP_W   = 32;          // top operand width
    localparam int unsigned VX_CORE_W = 8;           // leaf core operand width
    localparam int unsigned VX_PROD_W = 2 * VX_OP_W; // full product width
endpackage

// File: rtl/vx_core.sv
// Module: vx_core
// Leaf multiplier. Every output column k gets the count of bit pairs
// a[i]&b[k-i] in one combinational step, for all 2W-1 columns. Each
// column count is then weighted by 2^k and summed.
// Assumes unsigned operands; result is exact in 2W bits.
module vx_core #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned NCOL = 2 * W - 1;     // crosswise column count
    localparam int unsigned CW   = $clog2(W) + 1; // width of one column count

    logic [CW-1:0] col [NCOL];

    // Column sums: count the crosswise bit-pair products per column.
    always_comb begin
        for (int k = 0; k < NCOL; k++) begin
            col[k] = '0;
            for (int i = 0; i < W; i++) begin
                if ((k - i) >= 0 && (k - i) < W) begin
                    col[k] = col[k] + CW'(a[i] & b[k - i]);
                end
            end
        end
    end

    // Weighted merge of the column counts into the 2W-bit product.
    always_comb begin
        p = '0;
        for (int k = 0; k < NCOL; k++) begin
            p = p + ((2 * W)'(col[k]) << k);
        end
    end
endmodule

// File: rtl/vx_mid.sv
// Module: vx_mid
// Middle stage. Four leaf cores form the quarter products of a WxW
// multiply. They are combined as LL + ((LH + HL) << W/2) + (HH << W).
// Assumes W is even and equals twice the leaf core width.
module vx_mid #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned H  = W / 2; // half operand width
    localparam int unsigned PW = 2 * W; // product width

    logic [W-1:0] q_ll, q_lh, q_hl, q_hh;

    vx_core #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));
    vx_core #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(q_lh));
    vx_core #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(q_hl));
    vx_core #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(q_hh));

    // Align the quarter products and add them.
    always_comb begin
        p = PW'(q_ll)
          + ((PW'(q_lh) + PW'(q_hl)) << H)
          + (PW'(q_hh) << W);
    end
endmodule

// File: rtl/vx_csa.sv
// Module: vx_csa
// One row of 3:2 carry-save compressors across W bits. The carry word
// is returned already shifted one place left. A carry out of the top
// bit is dropped, which is harmless when the total fits in W bits.
module vx_csa #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    // Bitwise sum and shifted majority carry.
    always_comb begin
        s = x ^ y ^ z;
        c = ((x & y) | (x & z) | (y & z)) << 1;
    end
endmodule

// File: rtl/vx_ks_add.sv
// Module: vx_ks_add
// Kogge-Stone parallel-prefix adder of two W-bit words, result modulo
// 2^W. The prefix tree spans the low W-1 bits only, since no carry
// beyond bit W-1 is needed. It takes $clog2(W-1) stages, and each
// node feeds at most two nodes of the next stage.
module vx_ks_add #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int unsigned GW = W - 1;       // bits feeding carries
    localparam int unsigned ST = $clog2(GW);  // prefix stage count

    logic [GW-1:0] gs [ST+1];
    logic [GW-1:0] ps [ST];
    logic [W-1:0]  prop;

    // Prefix tree: merge generate/propagate pairs at doubling distances.
    always_comb begin
        gs[0] = a[GW-1:0] & b[GW-1:0];
        ps[0] = a[GW-1:0] ^ b[GW-1:0];
        for (int s = 0; s < ST; s++) begin
            for (int i = 0; i < GW; i++) begin
                if (i >= (1 << s)) begin
                    gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i - (1 << s)]);
                end else begin
                    gs[s+1][i] = gs[s][i];
                end
                if (s + 1 < ST) begin
                    if (i >= (1 << s)) begin
                        ps[s+1][i] = ps[s][i] & ps[s][i - (1 << s)];
                    end else begin
                        ps[s+1][i] = ps[s][i];
                    end
                end
            end
        end
    end

    // Final sum: half-sum bits XOR incoming group carries.
    always_comb begin
        prop = a ^ b;
        sum  = prop ^ {gs[ST], 1'b0};
    end
endmodule

// File: rtl/vx_mul32.sv
// Module: vx_mul32
// Top of the unsigned 32x32 vertical-crosswise multiplier. Four middle
// stages form the quarter products, which are aligned into four 64-bit
// words. Two carry-save rows reduce these to a sum and carry pair, and a
// Kogge-Stone adder resolves the pair. With OUT_REG=1 the product is
// registered on each cycle where in_valid is high, and out_valid is
// in_valid delayed one cycle.
// Assumes OP_W is a multiple of 4 and synchronous active-low reset.
module vx_mul32
    import vx_pkg::*;
#(
    parameter int unsigned OP_W    = VX_OP_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [2*OP_W-1:0] prod,
    output logic              out_valid
);
    localparam int unsigned H  = OP_W / 2; // half operand width
    localparam int unsigned PW = 2 * OP_W; // product width

    logic [OP_W-1:0] q_ll, q_lh, q_hl, q_hh;
    logic [PW-1:0]   w_ll, w_lh, w_hl, w_hh;
    logic [PW-1:0]   s1, c1, s2, c2;
    logic [PW-1:0]   ks_sum;

    vx_mid #(.W(H)) u_ll (.a(op_a[H-1:0]),    .b(op_b[H-1:0]),    .p(q_ll));
    vx_mid #(.W(H)) u_lh (.a(op_a[H-1:0]),    .b(op_b[OP_W-1:H]), .p(q_lh));
    vx_mid #(.W(H)) u_hl (.a(op_a[OP_W-1:H]), .b(op_b[H-1:0]),    .p(q_hl));
    vx_mid #(.W(H)) u_hh (.a(op_a[OP_W-1:H]), .b(op_b[OP_W-1:H]), .p(q_hh));

    // Align the quarter products to their weights in the full product.
    always_comb begin
        w_ll = PW'(q_ll);
        w_lh = PW'(q_lh) << H;
        w_hl = PW'(q_hl) << H;
        w_hh = PW'(q_hh) << OP_W;
    end

    vx_csa #(.W(PW)) u_csa0 (.x(w_ll), .y(w_lh), .z(w_hl), .s(s1), .c(c1));
    vx_csa #(.W(PW)) u_csa1 (.x(s1),   .y(c1),   .z(w_hh), .s(s2), .c(c2));

    vx_ks_add #(.W(PW)) u_ks (.a(s2), .b(c2), .sum(ks_sum));

    generate
        if (OUT_REG) begin : g_reg
            logic [PW-1:0] prod_q;
            logic          vld_q;

            // Output register: load on strobe, hold otherwise, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_q <= '0;
                    vld_q  <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        prod_q <= ks_sum;
                    end
                end
            end

            assign prod      = prod_q;
            assign out_valid = vld_q;
        end else begin : g_comb
            assign prod      = ks_sum;
            assign out_valid = in_valid;
        end
    endgenerate
endmodule

// File: rtl/vx_mul32_chk.sv
// Module: vx_mul32_chk
// Cycle-level checker bound to vx_mul32. It checks the registered
// timing, exact product, hold and zero behaviour, and that the prefix
// adder agrees with the carry-save pair it resolves. The timing checks
// apply only when the output register is present.
module vx_mul32_chk #(
    parameter int unsigned OP_W    = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [2*OP_W-1:0] prod,
    input logic              out_valid,
    input logic [2*OP_W-1:0] s2,
    input logic [2*OP_W-1:0] c2,
    input logic [2*OP_W-1:0] ks_sum
);
    localparam int unsigned PW = 2 * OP_W;

    // R7: the prefix adder equals a plain modular add of its inputs.
    p_ks_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ks_sum == PW'(s2 + c2));

    generate
        if (OUT_REG) begin : g_seq
            // R2: a strobe produces out_valid on the next cycle.
            p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R2: no strobe means no out_valid on the next cycle.
            p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R1: the registered product equals a behavioural multiply.
            p_exact_prod_r1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> prod == (PW'($past(op_a)) * PW'($past(op_b))));
            // R3: an idle cycle leaves the product untouched.
            p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(prod));
            // R5: a zero operand yields a zero product.
            p_zero_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (op_a == '0 || op_b == '0)) |=> prod == '0);
        end
    endgenerate
endmodule

bind vx_mul32 vx_mul32_chk #(.OP_W(OP_W), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .prod(prod), .out_valid(out_valid),
    .s2(s2), .c2(c2), .ks_sum(ks_sum)
);

// File: tb/tb_vx_mul32.sv
// Directed bench for vx_mul32. Each scenario task drives its operands
// and checks its own results. Inputs change at falling edges and
// outputs are sampled at falling edges.
module tb_vx_mul32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [63:0] prod;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;

    vx_mul32 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .prod(prod), .out_valid(out_valid)
    );

    always #10 clk = ~clk; // 50 MHz

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One strobed multiply: drive at a falling edge, check at the next one.
    task automatic mul_once(input string tag, input logic [31:0] a, input logic [31:0] b);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk64(tag, prod, 64'(a) * 64'(b));
        chk1({tag, " valid"}, out_valid, 1'b1);
    endtask

    // R4: reset clears both outputs even with the strobe held high.
    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678;
        repeat (2) @(negedge clk);
        chk64("R4 prod in reset", prod, 64'h0);
        chk1("R4 out_valid in reset", out_valid, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk1("R4 out_valid after release", out_valid, 1'b0);
        chk64("R4 prod after release", prod, 64'h0);
    endtask

    // R1: corner operands including all-ones and alternating bits.
    task automatic t_corners();
        mul_once("R1 max*max", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk64("R1 max*max literal", prod, 64'hFFFF_FFFE_0000_0001);
        mul_once("R1 alt a*5", 32'hAAAA_AAAA, 32'h5555_5555);
        mul_once("R1 alt a*a", 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        mul_once("R1 alt 5*max", 32'h5555_5555, 32'hFFFF_FFFF);
        mul_once("R1 top bits", 32'h8000_0000, 32'h8000_0000);
    endtask

    // R5: zero on either side gives zero.
    task automatic t_zero();
        mul_once("R5 0*max", 32'h0, 32'hFFFF_FFFF);
        chk64("R5 0*max literal", prod, 64'h0);
        mul_once("R5 max*0", 32'hDEAD_BEEF, 32'h0);
        chk64("R5 max*0 literal", prod, 64'h0);
    endtask

    // R6: identity operand returns the other operand.
    task automatic t_one();
        mul_once("R6 1*x", 32'h1, 32'hCAFE_F00D);
        chk64("R6 1*x literal", prod, 64'h0000_0000_CAFE_F00D);
        mul_once("R6 x*1", 32'hFFFF_FFFF, 32'h1);
        chk64("R6 x*1 literal", prod, 64'h0000_0000_FFFF_FFFF);
    endtask

    // R7: carry runs across the quarter seams and the upper half.
    task automatic t_carry();
        mul_once("R7 max*2", 32'hFFFF_FFFF, 32'h2);
        chk64("R7 max*2 literal", prod, 64'h0000_0001_FFFF_FFFE);
        mul_once("R7 seam", 32'h0001_FFFF, 32'h0001_FFFF);
        chk64("R7 seam literal", prod, 64'h0000_0003_FFFC_0001);
        mul_once("R7 half max", 32'h0000_FFFF, 32'hFFFF_0000);
        mul_once("R7 near max", 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    endtask

    // R3: idle cycles leave the product untouched while operands move.
    task automatic t_hold();
        logic [63:0] kept;
        mul_once("R3 load", 32'h1357_9BDF, 32'h2468_ACE0);
        kept = prod;
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
        @(negedge clk);
        chk64("R3 hold 1", prod, kept);
        chk1("R2 idle valid", out_valid, 1'b0);
        op_a = 32'h0; op_b = 32'h7;
        @(negedge clk);
        chk64("R3 hold 2", prod, kept);
    endtask

    // R2: consecutive strobes give consecutive results, one cycle late.
    task automatic t_stream();
        logic [31:0] va [4] = '{32'h0000_0003, 32'h8765_4321, 32'hFFFF_0001, 32'h0F0F_0F0F};
        logic [31:0] vb [4] = '{32'h0000_0007, 32'h1234_5678, 32'h0001_FFFF, 32'hF0F0_F0F0};
        for (int i = 0; i < 4; i++) begin
            op_a = va[i]; op_b = vb[i]; in_valid = 1'b1;
            @(negedge clk);
            chk64("R2 stream prod", prod, 64'(va[i]) * 64'(vb[i]));
            chk1("R2 stream valid", out_valid, 1'b1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk1("R2 stream end valid", out_valid, 1'b0);
    endtask

    // R1: pseudo-random operand pairs.
    task automatic t_random();
        logic [31:0] ra, rb;
        for (int i = 0; i < 200; i++) begin
            ra = $urandom();
            rb = $urandom();
            mul_once("R1 random", ra, rb);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        t_reset();
        t_corners();
        t_zero();
        t_one();
        t_carry();
        t_hold();
        t_stream();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule